// File: doc/BRIEF.md
# ATA PIO Cycle Timing Controller

This block runs programmed-I/O read and write cycles on one IDE channel that carries two drives. A host asks for a cycle with a single-clock request that carries an I/O address, a direction flag and write data. The block checks the address against the channel's command-block and control-block ports. If the address matches, it drives the chip selects, the register address and the read or write strobe. It then samples IORDY and times the recovery gap. When the cycle is finished it gives read data and a one-clock done pulse.

A 16-bit control word sets how the channel behaves. One bit turns the channel on and another bit picks which channel's addresses are decoded. There is one fast timing bank, with a programmable sample point and recovery time. Each drive has its own 4-bit group of flags. A drive whose fast flag is clear runs at fixed slow timing. The block follows the drive-select bit written to the device/head register, so each cycle uses the timing of the drive that is currently addressed.

Top module: `ata_pio_timing_ctrl`

## Requirements
- R1: After reset the control word reads 0, and both strobes and both chip selects are high. busy_o, done_o and timeout_o are low.
- R2: While control bit 15 is 0, no address matches. A request then asserts no chip select and no strobe, and done_o pulses in the clock that follows the request.
- R3: Control bit 14 picks the channel. With bit 14 = 0, the command block is at 0x1F0-0x1F7 (cs0, da = addr[2:0]) and the control register at 0x3F6 (cs1, da = 6). With bit 14 = 1, these are 0x170-0x177 and 0x376. Any other address behaves as in R2.
- R4: A drive on the fast bank keeps its strobe low for code+2 clocks, where the code is in bits 13:12. Recovery then lasts code+1 clocks, where the code is in bits 9:8. Drive 0's flags are in bits 3:0 and drive 1's flags are in bits 7:4. Within a group, bit 0 = fast bank and bit 1 = IORDY enable.
- R5: A drive whose fast flag is clear uses 6 strobe clocks and 4 recovery clocks, and ignores IORDY.
- R6: For a fast drive whose IORDY flag is set, IORDY low at the sample point keeps the strobe low until IORDY is seen high, plus one more clock. With the flag clear, the IORDY level has no effect.
- R7: If IORDY stays low for 256 clocks after the sample point, the strobe ends and timeout_o is high in the same clock as done_o.
- R8: The drive for a cycle is bit 4 of the latest write to command-block offset 6. That write itself still runs with the drive that was selected before it.
- R9: A control-word write made during a cycle is held. It takes effect on the clock edge that ends recovery. A write made while idle takes effect on the next edge.
- R10: done_o is high for exactly one clock, in the clock after the last recovery clock. Read data is the bus value at the edge where the strobe rises. Write data is driven with its output enable for the whole cycle.
- R11: A request that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control-word write strobe |
| cfg_wdata_i | input | 16 | Control-word write value |
| cfg_q_o | output | 16 | Control word now in force |
| req_i | input | 1 | Cycle request, one clock |
| req_we_i | input | 1 | 1 = write cycle |
| req_addr_i | input | ADDR_W | I/O address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Data from the last read cycle |
| done_o | output | 1 | Cycle complete, one clock |
| timeout_o | output | 1 | IORDY watchdog expired, with done_o |
| busy_o | output | 1 | Cycle in progress |
| ata_cs0_no | output | 1 | Command-block select, active low |
| ata_cs1_no | output | 1 | Control-block select, active low |
| ata_da_o | output | 3 | Register address |
| ata_dior_no | output | 1 | Read strobe, active low |
| ata_diow_no | output | 1 | Write strobe, active low |
| ata_dd_o | output | DATA_W | Data bus out |
| ata_dd_oe_o | output | 1 | Data bus output enable |
| ata_dd_i | input | DATA_W | Data bus in |
| ata_iordy_i | input | 1 | Drive ready, synchronous to clk_i |

## Verification
Chip select and strobe show up in the first clock after the request edge. The strobe stays low for the sample-point count, or longer when IORDY stretches it. busy_o stays high for the recovery count after that. done_o, and timeout_o if the watchdog fired, appear in the clock after recovery ends. A decode miss gives done_o in the first clock after the request. A reference model in the bench advances on each rising edge from the same inputs and is compared with every output at the falling edge. Directed checks count the low-strobe and recovery clocks between the request and done_o, and compare those counts with the values the requirements give.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int CFG_W       = 16;
  localparam int EN_BIT      = 15;
  localparam int CH_BIT      = 14;
  localparam int SP_LSB      = 12;
  localparam int RC_LSB      = 8;
  localparam int NIB_BITS    = 4;
  localparam int NIB_FAST    = 0;
  localparam int NIB_IORDY   = 1;
  localparam int N_DRV       = 2;
  localparam int DEVHEAD_OFS = 6;
  localparam int DRV_BIT     = 4;
  localparam int TIM_W       = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_ACT, ST_WAIT, ST_HOLD, ST_REC} seq_st_e;

  typedef struct packed {
    logic [TIM_W-1:0] act_len;
    logic [TIM_W-1:0] rec_len;
    logic             iordy_en;
  } drv_tim_t;
endpackage

// File: rtl/ata_pio_cfg.sv
module ata_pio_cfg
  import ata_pio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             open_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q, pend_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (wr_i && open_i) begin
      cfg_q    <= wdata_i;
      pend_v_q <= 1'b0;
    end else if (wr_i) begin
      pend_q   <= wdata_i;
      pend_v_q <= 1'b1;
    end else if (open_i && pend_v_q) begin
      cfg_q    <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;

  // R9: the control word only moves between cycles
  p_hold_mid_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(cfg_q));
  p_pend_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && pend_v_q && !wr_i) |=> (cfg_q == $past(pend_q)));
endmodule

// File: rtl/ata_pio_decode.sv
module ata_pio_decode #(
  parameter int ADDR_W = 10
) (
  input  logic              en_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              ctl_o,
  output logic [2:0]        da_o
);
  localparam int HI_W = ADDR_W - 3;
  localparam logic [HI_W-1:0]   CMD_PRI_HI = HI_W'(32'h1F0 >> 3);
  localparam logic [HI_W-1:0]   CMD_SEC_HI = HI_W'(32'h170 >> 3);
  localparam logic [ADDR_W-1:0] CTL_PRI    = ADDR_W'(32'h3F6);
  localparam logic [ADDR_W-1:0] CTL_SEC    = ADDR_W'(32'h376);

  logic cmd_hit, ctl_hit;

  assign cmd_hit = addr_i[ADDR_W-1:3] == (sec_i ? CMD_SEC_HI : CMD_PRI_HI);
  assign ctl_hit = addr_i == (sec_i ? CTL_SEC : CTL_PRI);
  assign hit_o   = en_i && (cmd_hit || ctl_hit);
  assign ctl_o   = !cmd_hit && ctl_hit;
  assign da_o    = cmd_hit ? addr_i[2:0] : 3'd6;
endmodule

// File: rtl/ata_pio_tsel.sv
module ata_pio_tsel
  import ata_pio_pkg::*;
#(
  parameter int SLOW_ACT = 6,
  parameter int SLOW_REC = 4
) (
  input  logic [N_DRV-1:0]           fast_i,
  input  logic [N_DRV-1:0]           iordy_en_i,
  input  logic [1:0]                 sp_code_i,
  input  logic [1:0]                 rc_code_i,
  output drv_tim_t [N_DRV-1:0]       tim_o
);
  logic [TIM_W-1:0] fast_act, fast_rec;

  assign fast_act = TIM_W'(sp_code_i) + TIM_W'(2);
  assign fast_rec = TIM_W'(rc_code_i) + TIM_W'(1);

  for (genvar g = 0; g < N_DRV; g++) begin : g_drv
    assign tim_o[g].act_len  = fast_i[g] ? fast_act : TIM_W'(SLOW_ACT);
    assign tim_o[g].rec_len  = fast_i[g] ? fast_rec : TIM_W'(SLOW_REC);
    assign tim_o[g].iordy_en = fast_i[g] && iordy_en_i[g];
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WDOG_CYC = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic                  hit_i,
  input  logic                  ctl_i,
  input  logic [2:0]            da_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  drv_tim_t [N_DRV-1:0]  tim_i,
  input  logic                  iordy_i,
  input  logic [DATA_W-1:0]     dd_i,
  output logic                  open_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  timeout_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  cs0_no,
  output logic                  cs1_no,
  output logic [2:0]            da_o,
  output logic                  dior_no,
  output logic                  diow_no,
  output logic [DATA_W-1:0]     dd_o,
  output logic                  dd_oe_o
);
  localparam int CNT_W = $clog2(WDOG_CYC);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  drv_tim_t          tim_q;
  logic              we_q, ctl_q, dev_q, done_q, to_q, to_pend_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              act, strobe, rec_last;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign rec_last = (st_q == ST_REC) && (cnt_nxt == CNT_W'(tim_q.rec_len));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      tim_q     <= '0;
      we_q      <= 1'b0;
      ctl_q     <= 1'b0;
      dev_q     <= 1'b0;
      da_q      <= '0;
      wd_q      <= '0;
      rd_q      <= '0;
      done_q    <= 1'b0;
      to_q      <= 1'b0;
      to_pend_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (hit_i) begin
            st_q      <= ST_ACT;
            cnt_q     <= '0;
            tim_q     <= tim_i[dev_q];
            we_q      <= we_i;
            ctl_q     <= ctl_i;
            da_q      <= da_i;
            wd_q      <= wdata_i;
            to_pend_q <= 1'b0;
            if (we_i && !ctl_i && da_i == 3'(DEVHEAD_OFS)) dev_q <= wdata_i[DRV_BIT];
          end else begin
            done_q <= 1'b1;
          end
        end
        ST_ACT: begin
          if (cnt_nxt == CNT_W'(tim_q.act_len)) begin
            cnt_q <= '0;
            if (tim_q.iordy_en && !iordy_i) begin
              st_q <= ST_WAIT;
            end else begin
              st_q <= ST_REC;
              if (!we_q) rd_q <= dd_i;
            end
          end else begin
            cnt_q <= cnt_nxt;
          end
        end
        ST_WAIT: begin
          if (iordy_i) begin
            st_q <= ST_HOLD;
          end else if (cnt_q == CNT_W'(WDOG_CYC - 1)) begin
            st_q      <= ST_REC;
            cnt_q     <= '0;
            to_pend_q <= 1'b1;
            if (!we_q) rd_q <= dd_i;
          end else begin
            cnt_q <= cnt_nxt;
          end
        end
        ST_HOLD: begin
          st_q  <= ST_REC;
          cnt_q <= '0;
          if (!we_q) rd_q <= dd_i;
        end
        ST_REC: begin
          if (rec_last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            to_q   <= to_pend_q;
          end else begin
            cnt_q <= cnt_nxt;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign act       = st_q != ST_IDLE;
  assign strobe    = st_q inside {ST_ACT, ST_WAIT, ST_HOLD};
  assign open_o    = !act || rec_last;
  assign busy_o    = act;
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rdata_o   = rd_q;
  assign cs0_no    = !(act && !ctl_q);
  assign cs1_no    = !(act && ctl_q);
  assign da_o      = act ? da_q : 3'd0;
  assign dior_no   = !(strobe && !we_q);
  assign diow_no   = !(strobe && we_q);
  assign dd_oe_o   = act && we_q;
  assign dd_o      = dd_oe_o ? wd_q : '0;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(st_q) == ST_REC || ($past(st_q) == ST_IDLE && $past(req_i))));
  p_timeout_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  p_wait_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> tim_q.iordy_en);
  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> ($stable(wd_q) && $stable(da_q) && $stable(we_q)));
endmodule

// File: rtl/ata_pio_timing_ctrl.sv
module ata_pio_timing_ctrl
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int SLOW_ACT = 6,
  parameter int SLOW_REC = 4,
  parameter int WDOG_CYC = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_q_o,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              busy_o,
  output logic              ata_cs0_no,
  output logic              ata_cs1_no,
  output logic [2:0]        ata_da_o,
  output logic              ata_dior_no,
  output logic              ata_diow_no,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe_o,
  input  logic [DATA_W-1:0] ata_dd_i,
  input  logic              ata_iordy_i
);
  logic [CFG_W-1:0]     cfg_q;
  logic                 open, hit, ctl;
  logic [2:0]           da;
  logic [N_DRV-1:0]     fast, rdy_en;
  drv_tim_t [N_DRV-1:0] tim;

  ata_pio_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .open_i  (open),
    .cfg_o   (cfg_q)
  );

  ata_pio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en_i   (cfg_q[EN_BIT]),
    .sec_i  (cfg_q[CH_BIT]),
    .addr_i (req_addr_i),
    .hit_o  (hit),
    .ctl_o  (ctl),
    .da_o   (da)
  );

  for (genvar g = 0; g < N_DRV; g++) begin : g_nib
    assign fast[g]   = cfg_q[NIB_BITS*g + NIB_FAST];
    assign rdy_en[g] = cfg_q[NIB_BITS*g + NIB_IORDY];
  end

  ata_pio_tsel #(.SLOW_ACT(SLOW_ACT), .SLOW_REC(SLOW_REC)) u_tsel (
    .fast_i     (fast),
    .iordy_en_i (rdy_en),
    .sp_code_i  (cfg_q[SP_LSB +: 2]),
    .rc_code_i  (cfg_q[RC_LSB +: 2]),
    .tim_o      (tim)
  );

  ata_pio_seq #(.DATA_W(DATA_W), .WDOG_CYC(WDOG_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (req_we_i),
    .hit_i     (hit),
    .ctl_i     (ctl),
    .da_i      (da),
    .wdata_i   (req_wdata_i),
    .tim_i     (tim),
    .iordy_i   (ata_iordy_i),
    .dd_i      (ata_dd_i),
    .open_o    (open),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .rdata_o   (rsp_rdata_o),
    .cs0_no    (ata_cs0_no),
    .cs1_no    (ata_cs1_no),
    .da_o      (ata_da_o),
    .dior_no   (ata_dior_no),
    .diow_no   (ata_diow_no),
    .dd_o      (ata_dd_o),
    .dd_oe_o   (ata_dd_oe_o)
  );

  assign cfg_q_o = cfg_q;

  // R2: no cycle starts while the channel is switched off
  p_off_no_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cfg_q[EN_BIT]));
endmodule

// File: tb/ata_pio_timing_ctrl_test.sv
`timescale 1ns/1ps
module ata_pio_timing_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_q_o;
  logic        req_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [9:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [15:0] rsp_rdata_o;
  logic        done_o, timeout_o, busy_o;
  logic        ata_cs0_no, ata_cs1_no, ata_dior_no, ata_diow_no, ata_dd_oe_o;
  logic [2:0]  ata_da_o;
  logic [15:0] ata_dd_o;
  logic [15:0] ata_dd_i = 16'hC000;
  logic        ata_iordy_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 0;

  always #2 clk_i = ~clk_i;

  ata_pio_timing_ctrl uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: state advanced on each rising edge
  int m_ph, m_k, m_w, m_r, m_act, m_rec;
  bit m_ien, m_we, m_ctl, m_dev, m_top, m_done, m_to, m_pv;
  logic [2:0]  m_da;
  logic [15:0] m_wd, m_rd, m_cfg, m_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_k = 0; m_w = 0; m_r = 0; m_act = 0; m_rec = 1;
      m_ien = 0; m_we = 0; m_ctl = 0; m_dev = 0; m_top = 0; m_done = 0; m_to = 0; m_pv = 0;
      m_da = 0; m_wd = 0; m_rd = 0; m_cfg = 0; m_pend = 0;
    end else begin
      bit open, cmd, ctl;
      int cbase, kaddr;
      open = (m_ph == 0) || (m_ph == 4 && m_r + 1 == m_rec);
      m_done = 0; m_to = 0;
      case (m_ph)
        0: if (req_i) begin
          cbase = m_cfg[14] ? 'h170 : 'h1F0;
          kaddr = m_cfg[14] ? 'h376 : 'h3F6;
          cmd = m_cfg[15] && int'(req_addr_i) >= cbase && int'(req_addr_i) < cbase + 8;
          ctl = m_cfg[15] && int'(req_addr_i) == kaddr;
          if (cmd || ctl) begin
            m_ph = 1; m_k = 0; m_we = req_we_i; m_ctl = ctl; m_top = 0;
            m_da = cmd ? req_addr_i[2:0] : 3'd6; m_wd = req_wdata_i;
            if (m_cfg[4*m_dev]) begin
              m_act = int'(m_cfg[13:12]) + 2; m_rec = int'(m_cfg[9:8]) + 1; m_ien = m_cfg[4*m_dev+1];
            end else begin
              m_act = 6; m_rec = 4; m_ien = 0;
            end
            if (cmd && req_we_i && req_addr_i[2:0] == 3'd6) m_dev = req_wdata_i[4];
          end else m_done = 1;
        end
        1: begin
          m_k++;
          if (m_k == m_act) begin
            if (m_ien && !ata_iordy_i) begin m_ph = 2; m_w = 0; end
            else begin m_ph = 4; m_r = 0; if (!m_we) m_rd = ata_dd_i; end
          end
        end
        2: if (ata_iordy_i) m_ph = 3;
           else if (m_w == 255) begin m_top = 1; m_ph = 4; m_r = 0; if (!m_we) m_rd = ata_dd_i; end
           else m_w++;
        3: begin m_ph = 4; m_r = 0; if (!m_we) m_rd = ata_dd_i; end
        default: begin
          m_r++;
          if (m_r == m_rec) begin m_ph = 0; m_done = 1; m_to = m_top; end
        end
      endcase
      if (cfg_wr_i) begin
        if (open) begin m_cfg = cfg_wdata_i; m_pv = 0; end
        else begin m_pend = cfg_wdata_i; m_pv = 1; end
      end else if (open && m_pv) begin
        m_cfg = m_pend; m_pv = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (chk_en) begin
      bit st;
      st = m_ph inside {1, 2, 3};
      chk(busy_o, m_ph != 0, "R11 busy");
      chk(ata_dior_no, !(st && !m_we), "R4 read strobe");
      chk(ata_diow_no, !(st && m_we), "R4 write strobe");
      chk(ata_cs0_no, !(m_ph != 0 && !m_ctl), "R3 cs0");
      chk(ata_cs1_no, !(m_ph != 0 && m_ctl), "R3 cs1");
      if (m_ph != 0) chk(ata_da_o, m_da, "R3 da");
      chk(ata_dd_oe_o, m_ph != 0 && m_we, "R10 data enable");
      if (m_ph != 0 && m_we) chk(ata_dd_o, m_wd, "R10 write data");
      chk(done_o, m_done, "R10 done");
      chk(timeout_o, m_to, "R7 timeout");
      chk(rsp_rdata_o, m_rd, "R10 read data");
      chk(cfg_q_o, m_cfg, "R9 control word");
    end
  end

  // data bus changes each clock so the capture edge is visible
  initial forever begin
    @(negedge clk_i);
    ata_dd_i = ata_dd_i + 16'h0001;
  end

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk_i); cfg_wr_i = 1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_wr_i = 0;
  endtask

  int a_n, r_n;
  bit cs0_seen, cs1_seen, to_seen;

  task automatic cycle(input logic [9:0] a, input bit we, input logic [15:0] wd);
    @(negedge clk_i); req_i = 1; req_addr_i = a; req_we_i = we; req_wdata_i = wd;
    @(negedge clk_i); req_i = 0;
    a_n = 0; r_n = 0; cs0_seen = 0; cs1_seen = 0; to_seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (!ata_dior_no || !ata_diow_no) a_n++;
      else if (busy_o) r_n++;
      if (!ata_cs0_no) cs0_seen = 1;
      if (!ata_cs1_no) cs1_seen = 1;
      if (done_o) begin to_seen = timeout_o; break; end
      @(negedge clk_i);
    end
    @(negedge clk_i);
    chk(done_o, 0, "R10 done one clock wide");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    chk_en = 1;
    @(negedge clk_i);
    // R1
    chk({ata_dior_no, ata_diow_no, ata_cs0_no, ata_cs1_no}, 4'hF, "R1 strobes/selects idle");
    chk({busy_o, done_o, timeout_o}, 0, "R1 status low");
    chk(cfg_q_o, 0, "R1 control word");

    // R2: channel off
    cycle(10'h1F0, 0, 0);
    chk(a_n, 0, "R2 no strobe when off");
    chk(cs0_seen | cs1_seen, 0, "R2 no select when off");

    set_cfg(16'h9201);
    chk(cfg_q_o, 16'h9201, "R9 idle write immediate");
    // R4 fast read
    cycle(10'h1F0, 0, 0);
    chk(a_n, 3, "R4 fast strobe length");
    chk(r_n, 3, "R4 fast recovery length");
    // R3 decode
    cycle(10'h170, 0, 0);
    chk(a_n + int'(cs0_seen), 0, "R3 other channel not decoded");
    cycle(10'h3F6, 0, 0);
    chk(cs1_seen, 1, "R3 control register select");
    chk(a_n, 3, "R3 control register cycle");
    // R4 write
    cycle(10'h1F2, 1, 16'h5A5A);
    chk(a_n, 3, "R4 fast write strobe");
    // R8 select drive 1 (slow)
    cycle(10'h1F6, 1, 16'h0010);
    chk(a_n, 3, "R8 select write uses previous drive");
    cycle(10'h1F7, 0, 0);
    chk(a_n, 6, "R5 slow strobe length");
    chk(r_n, 4, "R5 slow recovery length");

    // R6: IORDY ignored when flag clear
    set_cfg(16'h9211);
    ata_iordy_i = 0;
    cycle(10'h1F0, 0, 0);
    chk(a_n, 3, "R6 IORDY ignored without flag");
    // R6: stretch
    set_cfg(16'h9231);
    fork
      cycle(10'h1F0, 0, 0);
      begin @(negedge clk_i); repeat (6) @(negedge clk_i); ata_iordy_i = 1; end
    join
    chk(a_n, 7, "R6 IORDY stretch");
    chk(r_n, 3, "R6 recovery after stretch");
    cycle(10'h1F0, 0, 0);
    chk(a_n, 3, "R6 IORDY high at sample point");
    // R7 watchdog
    ata_iordy_i = 0;
    cycle(10'h1F0, 0, 0);
    chk(a_n, 259, "R7 watchdog strobe length");
    chk(to_seen, 1, "R7 timeout flagged");
    // R5 slow drive ignores IORDY
    set_cfg(16'h9221);
    cycle(10'h1F0, 0, 0);
    chk(a_n, 6, "R5 slow ignores IORDY");
    ata_iordy_i = 1;

    // R9 write during a cycle
    fork
      cycle(10'h1F0, 0, 0);
      begin
        @(negedge clk_i); repeat (2) @(negedge clk_i);
        cfg_wr_i = 1; cfg_wdata_i = 16'hB311;
        @(negedge clk_i); cfg_wr_i = 0;
        chk(cfg_q_o, 16'h9221, "R9 held during cycle");
      end
    join
    chk(a_n, 6, "R9 cycle keeps old timing");
    chk(cfg_q_o, 16'hB311, "R9 applied after recovery");
    cycle(10'h1F0, 0, 0);
    chk(a_n, 5, "R9 new timing in force");
    chk(r_n, 4, "R9 new recovery in force");

    // R11 request while busy
    fork
      cycle(10'h1F0, 0, 0);
      begin
        @(negedge clk_i); repeat (2) @(negedge clk_i);
        req_i = 1; req_we_i = 1; req_addr_i = 10'h1F6; req_wdata_i = 16'h0000;
        @(negedge clk_i); req_i = 0; req_we_i = 0;
      end
    join
    chk(a_n, 5, "R11 busy cycle unaffected");
    cycle(10'h1F0, 0, 0);
    chk(a_n, 5, "R11 ignored write did not change drive");

    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule